// File: doc/BRIEF.md
# Fault Isolation Register Bank

This block keeps a 64-bit fault register together with its mask, two action registers and a capture register. It sits on a simple register bus that carries 8-byte words. Software can replace the fault and mask values outright. It can also clear chosen bits by writing to an AND alias, or set chosen bits by writing to an OR alias. Hardware fault pulses arrive on a 64-bit input and are merged into the fault register on every cycle, so no pulse is lost.

Three outputs report the combined state:
- `fault_unmasked` is high whenever any fault bit is set and not masked.
- `fault_recov` is high when such a fault has its action bits selecting the recoverable class.
- `fault_xstop` is high when such a fault has its action bits selecting the checkstop class.

The capture register records the lowest unmasked fault bit, but only while it is empty. It then keeps that bit until software writes to it. Any write empties it, whatever the data.

Accesses must be full, aligned 8-byte words. The word index is the byte address shifted right by three. Each accepted request gets a response one cycle later. An access that is misaligned, partial or aimed at an unused index is refused and flagged.

Top module: `fir_bank`

## Requirements
- R1: After reset all five stored registers are zero, `fault_unmasked`, `fault_recov` and `fault_xstop` are low, and no response is pending.
- R2: A write replaces the whole register at these word indices:

  | Index | Register |
  |-------|----------|
  | 0 | fault |
  | 3 | mask |
  | 6 | action 0 |
  | 7 | action 1 |
- R3: A write to index 1 ANDs the data into the fault register. A write to index 4 ANDs the data into the mask register. A zero data bit clears the stored bit.
- R4: A write to index 2 ORs the data into the fault register. A write to index 5 ORs the data into the mask register.
- R5: Every set bit of `hw_fault` is ORed into the fault register at each clock edge. This is applied after any bus operation in the same cycle, so a bus write of zero cannot clear a bit that hardware raises in that cycle.
- R6: The capture register behaves as follows:
  - It sits at index 8.
  - Any write to it sets it to zero, whatever the data.
  - While it is zero and not being written, it takes on, at the next edge, only the lowest set bit of (fault AND NOT mask).
  - Once nonzero, it holds its value until it is written.
- R7: `fault_unmasked` is high exactly when (fault AND NOT mask) is nonzero.
- R8: The two action outputs are defined per bit, over bits that are set in the fault register and clear in the mask register:
  - `fault_recov` is high when any such bit has action 0 = 0 and action 1 = 1.
  - `fault_xstop` is high when any such bit has action 0 = 0 and action 1 = 0.
- R9: Every request with `req_valid` high gets `rsp_valid` high one cycle later.
  - For a read, `rsp_rdata` is the register value before that edge. Indices 1 and 2 read the fault register, and indices 4 and 5 read the mask register.
  - For a write, `rsp_rdata` is zero.
- R10: A request is refused if any of these holds:
  - the byte address has nonzero low three bits;
  - `req_be` is not all ones;
  - the word index is above 8.

  A refused request changes no register, returns `rsp_rdata` of zero and raises `rsp_err` together with `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (7) | Byte address |
| req_be | input | DW/8 (8) | Byte enables, must be all ones |
| req_wdata | input | DW (64) | Write data |
| hw_fault | input | DW (64) | Hardware fault pulses, ORed into the fault register |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_rdata | output | DW (64) | Read data, zero for writes and refused requests |
| rsp_err | output | 1 | Previous request was refused |
| fault_unmasked | output | 1 | Any unmasked fault bit set |
| fault_recov | output | 1 | Unmasked fault of the recoverable action class |
| fault_xstop | output | 1 | Unmasked fault of the checkstop action class |

## Verification
The bench drives a bus write of zero to the fault register while a hardware pulse arrives in the same cycle. A design that ordered these the wrong way would lose the pulse.

It checks that the capture register keeps its first bit after the faulting bit is cleared. It also checks that a write of all ones still empties the capture register. A design that re-sampled on every cycle, or stored the write data, would show a different value.

Refused accesses are tested separately: partial byte enables, a misaligned address and an unused index are each followed by read-backs. Those read-backs expose any register that a refused access changed. The action-class outputs are stepped through every combination of action bits, which catches swapped encodings.

// File: rtl/fir_pkg.sv
package fir_pkg;
    localparam int NUM_IDX = 9;

    localparam logic [3:0] IDX_FAULT     = 4'd0;
    localparam logic [3:0] IDX_FAULT_AND = 4'd1;
    localparam logic [3:0] IDX_FAULT_OR  = 4'd2;
    localparam logic [3:0] IDX_MASK      = 4'd3;
    localparam logic [3:0] IDX_MASK_AND  = 4'd4;
    localparam logic [3:0] IDX_MASK_OR   = 4'd5;
    localparam logic [3:0] IDX_ACT0      = 4'd6;
    localparam logic [3:0] IDX_ACT1      = 4'd7;
    localparam logic [3:0] IDX_CAPT      = 4'd8;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_SET  = 2'd1,
        OP_AND  = 2'd2,
        OP_OR   = 2'd3
    } wr_op_e;
endpackage

// File: rtl/fir_decode.sv
module fir_decode #(
    parameter int ADDR_W = 7,
    parameter int BE_W   = 8,
    localparam int IDX_W = ADDR_W - 3
) (
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    output logic              acc_ok,
    output logic              acc_err,
    output logic [IDX_W-1:0]  acc_idx
);
    logic aligned;
    logic full_word;
    logic in_range;

    always_comb begin
        acc_idx   = req_addr[ADDR_W-1:3];
        aligned   = (req_addr[2:0] == 3'b000);
        full_word = &req_be;
        in_range  = (int'(acc_idx) < fir_pkg::NUM_IDX);
        acc_ok    = req_valid && aligned && full_word && in_range;
        acc_err   = req_valid && !(aligned && full_word && in_range);
    end
endmodule

// File: rtl/fir_alias_reg.sv
module fir_alias_reg #(
    parameter int DW = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  fir_pkg::wr_op_e op,
    input  logic [DW-1:0]  wdata,
    input  logic [DW-1:0]  set_bits,
    output logic [DW-1:0]  q
);
    import fir_pkg::*;

    logic [DW-1:0] val_d, val_q;
    logic [DW-1:0] bus_val;

    always_comb begin
        unique case (op)
            OP_SET:  bus_val = wdata;
            OP_AND:  bus_val = val_q & wdata;
            OP_OR:   bus_val = val_q | wdata;
            default: bus_val = val_q;
        endcase
        val_d = bus_val | set_bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign q = val_q;

    // Hardware set bits are never lost to a same-cycle bus operation
    assert_set_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q & $past(set_bits)) == $past(set_bits)));
endmodule

// File: rtl/fir_capture.sv
module fir_capture #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [DW-1:0] cand,
    output logic [DW-1:0] q
);
    logic [DW-1:0] cap_d, cap_q;
    logic [DW-1:0] lowest;

    always_comb begin
        lowest = cand & (~cand + {{(DW-1){1'b0}}, 1'b1});
        if (clr)              cap_d = '0;
        else if (cap_q == '0) cap_d = lowest;
        else                  cap_d = cap_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign q = cap_q;

    assert_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q));
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q != '0 && !clr) |=> $stable(q));
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));
endmodule

// File: rtl/fir_bank.sv
module fir_bank #(
    parameter int DW     = 64,
    parameter int ADDR_W = 7,
    localparam int BE_W  = DW / 8,
    localparam int IDX_W = ADDR_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [DW-1:0]     req_wdata,
    input  logic [DW-1:0]     hw_fault,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_rdata,
    output logic              rsp_err,
    output logic              fault_unmasked,
    output logic              fault_recov,
    output logic              fault_xstop
);
    import fir_pkg::*;

    localparam int NREG = 4;   // 0 fault, 1 mask, 2 action 0, 3 action 1

    typedef struct packed {
        logic          vld;
        logic          err;
        logic [DW-1:0] data;
    } rsp_t;

    logic             acc_ok, acc_err;
    logic [IDX_W-1:0] acc_idx;
    logic [3:0]       idx4;
    wr_op_e           reg_op [NREG];
    logic [DW-1:0]    reg_q  [NREG];
    logic [DW-1:0]    capt_q;
    logic             capt_clr;
    logic [DW-1:0]    live;
    rsp_t             rsp_d, rsp_q;

    fir_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_dec (
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .acc_ok    (acc_ok),
        .acc_err   (acc_err),
        .acc_idx   (acc_idx)
    );

    assign idx4 = 4'(acc_idx);

    always_comb begin
        for (int r = 0; r < NREG; r++) reg_op[r] = OP_NONE;
        capt_clr = 1'b0;
        if (acc_ok && req_write) begin
            unique case (idx4)
                IDX_FAULT:     reg_op[0] = OP_SET;
                IDX_FAULT_AND: reg_op[0] = OP_AND;
                IDX_FAULT_OR:  reg_op[0] = OP_OR;
                IDX_MASK:      reg_op[1] = OP_SET;
                IDX_MASK_AND:  reg_op[1] = OP_AND;
                IDX_MASK_OR:   reg_op[1] = OP_OR;
                IDX_ACT0:      reg_op[2] = OP_SET;
                IDX_ACT1:      reg_op[3] = OP_SET;
                IDX_CAPT:      capt_clr  = 1'b1;
                default:       ;
            endcase
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] set_in;
        if (g == 0) begin : g_hw
            assign set_in = hw_fault;
        end else begin : g_none
            assign set_in = '0;
        end
        fir_alias_reg #(.DW(DW)) u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .op       (reg_op[g]),
            .wdata    (req_wdata),
            .set_bits (set_in),
            .q        (reg_q[g])
        );
    end

    assign live = reg_q[0] & ~reg_q[1];

    fir_capture #(.DW(DW)) u_capt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (capt_clr),
        .cand  (live),
        .q     (capt_q)
    );

    always_comb begin
        rsp_d      = '0;
        rsp_d.vld  = req_valid;
        rsp_d.err  = acc_err;
        if (acc_ok && !req_write) begin
            unique case (idx4)
                IDX_FAULT, IDX_FAULT_AND, IDX_FAULT_OR: rsp_d.data = reg_q[0];
                IDX_MASK, IDX_MASK_AND, IDX_MASK_OR:    rsp_d.data = reg_q[1];
                IDX_ACT0:                               rsp_d.data = reg_q[2];
                IDX_ACT1:                               rsp_d.data = reg_q[3];
                IDX_CAPT:                               rsp_d.data = capt_q;
                default:                                rsp_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid      = rsp_q.vld;
    assign rsp_err        = rsp_q.err;
    assign rsp_rdata      = rsp_q.data;
    assign fault_unmasked = |live;
    assign fault_recov    = |(live & ~reg_q[2] &  reg_q[3]);
    assign fault_xstop    = |(live & ~reg_q[2] & ~reg_q[3]);

    assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_spurious_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_err_zero_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == '0));
    assert_reject_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !acc_ok && hw_fault == '0) |=>
            ($stable(reg_q[0]) && $stable(reg_q[1]) && $stable(reg_q[2]) && $stable(reg_q[3])));
    assert_class_implies_any_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_recov || fault_xstop) |-> fault_unmasked);
endmodule

// File: tb/fir_bank_test.sv
module fir_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [6:0]  req_addr = '0;
    logic [7:0]  req_be = '0;
    logic [63:0] req_wdata = '0;
    logic [63:0] hw_fault = '0;
    logic        rsp_valid, rsp_err;
    logic [63:0] rsp_rdata;
    logic        fault_unmasked, fault_recov, fault_xstop;

    int checks = 0;
    int fails  = 0;

    logic [63:0] q_data [$];
    logic        q_err  [$];
    string       q_tag  [$];

    always #5 clk = ~clk;

    fir_bank uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .hw_fault(hw_fault), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .fault_unmasked(fault_unmasked),
        .fault_recov(fault_recov), .fault_xstop(fault_xstop)
    );

    // Monitor: compare each response against the queued expectation
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            checks++;
            if (q_data.size() == 0) begin
                fails++;
                $display("FAIL R9 unexpected response: actual data %h, expected none", rsp_rdata);
            end else begin
                logic [63:0] ed;
                logic        ee;
                string       et;
                ed = q_data.pop_front();
                ee = q_err.pop_front();
                et = q_tag.pop_front();
                if (rsp_rdata !== ed || rsp_err !== ee) begin
                    fails++;
                    $display("FAIL %s: actual data %h err %b, expected data %h err %b",
                             et, rsp_rdata, rsp_err, ed, ee);
                end
            end
        end
    end

    task automatic access(input bit wr, input logic [6:0] addr, input logic [7:0] be,
                          input logic [63:0] data, input logic [63:0] hw,
                          input logic [63:0] exp_data, input bit exp_err, input string tag);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_be    = be;
        req_wdata = data;
        hw_fault  = hw;
        q_data.push_back(exp_data);
        q_err.push_back(exp_err);
        q_tag.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        req_wdata = '0;
        hw_fault  = '0;
    endtask

    task automatic wr(input logic [6:0] addr, input logic [63:0] data, input string tag);
        access(1'b1, addr, 8'hFF, data, 64'd0, 64'd0, 1'b0, tag);
    endtask

    task automatic rd(input logic [6:0] addr, input logic [63:0] exp, input string tag);
        access(1'b0, addr, 8'hFF, 64'd0, 64'd0, exp, 1'b0, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk3(input logic [2:0] act, input logic [2:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual {unmasked,recov,xstop} %b, expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] outs();
        return {fault_unmasked, fault_recov, fault_xstop};
    endfunction

    localparam logic [63:0] PAT_A = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] B4    = 64'h10;
    localparam logic [63:0] B2    = 64'h4;
    localparam logic [63:0] B40   = 64'h1 << 40;

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [63:0] ef, em;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk3(outs(), 3'b000, "R1 outputs after reset");
        rd(7'h00, 64'd0, "R1 fault reset");
        rd(7'h18, 64'd0, "R1 mask reset");
        rd(7'h30, 64'd0, "R1 act0 reset");
        rd(7'h38, 64'd0, "R1 act1 reset");
        rd(7'h40, 64'd0, "R1 capture reset");

        // R2 direct writes
        em = '1;
        wr(7'h18, em, "R2 mask write");
        ef = PAT_A;
        wr(7'h00, ef, "R2 fault write");
        rd(7'h00, ef, "R2 fault readback");
        chk3(outs(), 3'b000, "R7 all masked");

        // R3 and R4 on fault
        ef = ef & 64'hFFFF_0000_FFFF_0000;
        wr(7'h08, 64'hFFFF_0000_FFFF_0000, "R3 fault and-alias write");
        rd(7'h00, ef, "R3 fault after and-alias");
        ef = ef | B4;
        wr(7'h10, B4, "R4 fault or-alias write");
        rd(7'h10, ef, "R9 fault read through or-alias index");

        // R3 on mask: unmask bit 4
        em = em & ~B4;
        wr(7'h20, ~B4, "R3 mask and-alias write");
        rd(7'h28, em, "R9 mask read through alias index");
        idle(1);
        chk3(outs(), 3'b101, "R8 bit4 act0=0 act1=0 is xstop");
        rd(7'h40, B4, "R6 capture latched bit4");

        // R8 action classes
        wr(7'h38, B4, "R2 act1 write");
        rd(7'h38, B4, "R2 act1 readback");
        chk3(outs(), 3'b110, "R8 act0=0 act1=1 is recov");
        wr(7'h30, B4, "R2 act0 write");
        chk3(outs(), 3'b100, "R8 act0=1 act1=1 neither class");
        wr(7'h38, 64'd0, "R2 act1 clear");
        chk3(outs(), 3'b100, "R8 act0=1 act1=0 neither class");

        // R4 mask or-alias, R6 write of ones empties capture
        em = em | B4;
        wr(7'h28, B4, "R4 mask or-alias write");
        chk3(outs(), 3'b000, "R7 bit4 masked again");
        wr(7'h40, '1, "R6 capture write all ones");
        idle(1);
        rd(7'h40, 64'd0, "R6 capture zeroed by write");

        // R5 hardware fault beats a same-cycle zero write
        access(1'b1, 7'h00, 8'hFF, 64'd0, B40, 64'd0, 1'b0, "R5 write zero with hw pulse");
        ef = B40;
        rd(7'h00, ef, "R5 hw bit kept over zero write");
        access(1'b0, 7'h40, 8'hFF, 64'd0, B2, 64'd0, 1'b0, "R5 read with hw pulse");
        ef = ef | B2;
        rd(7'h00, ef, "R5 hw pulse ORed in");

        // R6 lowest bit captured, then held
        em = em & ~(B40 | B2);
        wr(7'h20, ~(B40 | B2), "R3 mask and-alias unmask 2 and 40");
        idle(1);
        chk3(outs(), 3'b101, "R7 R8 unmasked bits are xstop");
        rd(7'h40, B2, "R6 capture takes lowest unmasked bit");
        ef = ef & ~B2;
        wr(7'h08, ~B2, "R3 clear bit2");
        idle(1);
        rd(7'h40, B2, "R6 capture holds after source cleared");

        // R10 refused accesses
        access(1'b1, 7'h48, 8'hFF, '1, 64'd0, 64'd0, 1'b1, "R10 write unused index");
        access(1'b0, 7'h48, 8'hFF, 64'd0, 64'd0, 64'd0, 1'b1, "R10 read unused index");
        access(1'b1, 7'h00, 8'h0F, '1, 64'd0, 64'd0, 1'b1, "R10 partial byte enables");
        access(1'b1, 7'h1C, 8'hFF, '1, 64'd0, 64'd0, 1'b1, "R10 misaligned mask write");
        access(1'b0, 7'h04, 8'hFF, 64'd0, 64'd0, 64'd0, 1'b1, "R10 misaligned read");
        rd(7'h00, ef, "R10 fault unchanged after refused");
        rd(7'h18, em, "R10 mask unchanged after refused");
        rd(7'h38, 64'd0, "R10 act1 unchanged after refused");

        idle(3);
        checks++;
        if (q_data.size() != 0) begin
            fails++;
            $display("FAIL R9 missing responses: actual %0d pending, expected 0", q_data.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule